// File: doc/BRIEF.md
# Four-Key Setpoint Menu Controller

This block turns four active-low push buttons into menu actions for a voltage setpoint. Each button line first passes through a two-stage synchronizer. A per-key timer then confirms the press and the release. A key counts as pressed only if its line is still low once a programmable wait has run out. It counts as released only if its line is still high once the same wait has run out after it went high. Only the final sample decides; bounces inside the window are ignored.

Confirmed presses drive a three-screen state machine:
- **Home** shows the sampled voltage.
- **Edit** adjusts the setpoint.
- **Calibration** is used for converter calibration.

The block provides the current screen code, the setpoint value and a one-cycle strobe that marks every change of the setpoint. The wait is given in clock cycles, for example 500 000 cycles for 10 ms at 50 MHz. Display driving is left to other logic.

Key roles, by bit of `key_n`:
- Bit 0 is enter/advance.
- Bit 1 is increment.
- Bit 2 is decrement.
- Bit 3 is home.

Top module: `keypad_menu`

## Requirements
- R1: After reset the screen code is 0 (home), the setpoint equals SET_INIT and the change strobe is low.
- R2: A low level on a key line shorter than DLY_CYC cycles produces no action; a low level still present once DLY_CYC cycles of checking have run out produces exactly one action.
- R3: After a confirmed press, a key can act again only after a confirmed release: the line must still be high once DLY_CYC cycles have run out after it rose. A short high blip while the key is held produces no second action.
- R4: Holding a key for any length of time produces a single action (no auto-repeat).
- R5: On the home screen (code 0), enter (bit 0) switches to the edit screen (code 1). The screen code never takes the value 3.
- R6: On the edit screen, increment (bit 1) adds one to the setpoint when the result does not exceed SET_MAX. At SET_MAX it has no effect. The strobe is high for exactly the one cycle in which the new value first appears.
- R7: On the edit screen, decrement (bit 2) subtracts one when the result does not go below SET_MIN. At SET_MIN it has no effect and gives no strobe.
- R8: On the edit screen, enter switches to the calibration screen (code 2).
- R9: Home (bit 3) returns to screen code 0 from any screen and leaves the setpoint unchanged.
- R10: Enter on the calibration screen has no effect. Increment and decrement on the home and calibration screens leave the setpoint unchanged and give no strobe.
- R11: When presses are confirmed in the same cycle, only the highest-priority key acts, in the order home > decrement > increment > enter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_n | input | 4 | Raw button lines, active low (bit 0 enter, 1 increment, 2 decrement, 3 home) |
| screen | output | 2 | Screen code: 0 home, 1 edit, 2 calibration |
| setpoint | output | SET_W | Current setpoint |
| setpoint_chg | output | 1 | One-cycle strobe when the setpoint changes |

## Verification
The assertions check the following on every cycle:
- The setpoint stays inside its limits.
- The setpoint moves only by one, only together with the strobe, and only from the edit screen.
- A confirmed press pulse lasts one cycle and follows a low sample.
- A release is confirmed only on a high sample.
- A home press always lands on screen 0.

The ordering effects can only be shown by the bench's scenarios, with its cycle-level model compared on every clock:
- a glitch shorter than the wait,
- a blip during a hold,
- long holds with no repeat,
- limit hits,
- two keys confirmed in the same cycle.

// File: rtl/keymenu_pkg.sv
package keymenu_pkg;

    typedef enum logic [1:0] {
        SCR_HOME = 2'd0,
        SCR_EDIT = 2'd1,
        SCR_CAL  = 2'd2
    } screen_e;

    typedef enum logic [1:0] {
        DB_UP,
        DB_CHK_DN,
        DB_DOWN,
        DB_CHK_UP
    } db_state_e;

    localparam int NUM_KEYS = 4;
    localparam int K_ENTER  = 0;
    localparam int K_INC    = 1;
    localparam int K_DEC    = 2;
    localparam int K_HOME   = 3;

endpackage

// File: rtl/key_confirm.sv
module key_confirm
    import keymenu_pkg::*;
#(
    parameter int DLY_CYC     = 500000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_n,
    output logic press_o
);
    localparam int CW = (DLY_CYC > 1) ? $clog2(DLY_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DLY_CYC - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        db_state_e              state;
        logic [CW-1:0]          cnt;
        logic                   press;
    } kc_t;

    kc_t r_d, r_q;
    logic lvl;

    assign lvl = r_q.sync[SYNC_STAGES-1];

    always_comb begin
        r_d       = r_q;
        r_d.sync  = {r_q.sync[SYNC_STAGES-2:0], key_n};
        r_d.press = 1'b0;
        unique case (r_q.state)
            DB_UP: begin
                if (!lvl) begin
                    r_d.state = DB_CHK_DN;
                    r_d.cnt   = '0;
                end
            end
            DB_CHK_DN: begin
                if (r_q.cnt == CNT_LAST) begin
                    if (!lvl) begin
                        r_d.state = DB_DOWN;
                        r_d.press = 1'b1;
                    end else begin
                        r_d.state = DB_UP;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            DB_DOWN: begin
                if (lvl) begin
                    r_d.state = DB_CHK_UP;
                    r_d.cnt   = '0;
                end
            end
            DB_CHK_UP: begin
                if (r_q.cnt == CNT_LAST) begin
                    r_d.state = lvl ? DB_UP : DB_DOWN;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.state = DB_UP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.sync  <= '1;
            r_q.state <= DB_UP;
            r_q.cnt   <= '0;
            r_q.press <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign press_o = r_q.press;

    AST_PRESS_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.press |-> !$past(lvl)); // R2
    AST_PRESS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.press |=> !r_q.press); // R4
    AST_RELEASE_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == DB_UP && $past(r_q.state) == DB_CHK_UP) |-> $past(lvl)); // R3

endmodule

// File: rtl/key_priority.sv
module key_priority
    import keymenu_pkg::*;
(
    input  logic [NUM_KEYS-1:0] press,
    output logic [NUM_KEYS-1:0] grant
);
    always_comb begin
        grant = '0;
        for (int i = NUM_KEYS - 1; i >= 0; i--) begin
            if (press[i] && grant == '0) grant[i] = 1'b1;
        end
    end
endmodule

// File: rtl/menu_fsm.sv
module menu_fsm
    import keymenu_pkg::*;
#(
    parameter int SET_W    = 8,
    parameter int SET_MIN  = 0,
    parameter int SET_MAX  = 200,
    parameter int SET_INIT = 50
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] grant,
    output screen_e             screen_o,
    output logic [SET_W-1:0]    set_o,
    output logic                chg_o
);
    localparam logic [SET_W-1:0] LIM_LO = SET_W'(SET_MIN);
    localparam logic [SET_W-1:0] LIM_HI = SET_W'(SET_MAX);
    localparam logic [SET_W-1:0] START  = SET_W'(SET_INIT);

    typedef struct packed {
        screen_e          scr;
        logic [SET_W-1:0] set;
        logic             chg;
    } mf_t;

    mf_t m_d, m_q;

    always_comb begin
        m_d     = m_q;
        m_d.chg = 1'b0;
        if (grant[K_HOME]) begin
            m_d.scr = SCR_HOME;
        end else if (grant[K_DEC]) begin
            if (m_q.scr == SCR_EDIT && m_q.set > LIM_LO) begin
                m_d.set = m_q.set - 1'b1;
                m_d.chg = 1'b1;
            end
        end else if (grant[K_INC]) begin
            if (m_q.scr == SCR_EDIT && m_q.set < LIM_HI) begin
                m_d.set = m_q.set + 1'b1;
                m_d.chg = 1'b1;
            end
        end else if (grant[K_ENTER]) begin
            if (m_q.scr == SCR_HOME)      m_d.scr = SCR_EDIT;
            else if (m_q.scr == SCR_EDIT) m_d.scr = SCR_CAL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q.scr <= SCR_HOME;
            m_q.set <= START;
            m_q.chg <= 1'b0;
        end else begin
            m_q <= m_d;
        end
    end

    assign screen_o = m_q.scr;
    assign set_o    = m_q.set;
    assign chg_o    = m_q.chg;

    AST_SET_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.set >= LIM_LO && m_q.set <= LIM_HI); // R6
    AST_STEP_OF_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.chg |-> (m_q.set == $past(m_q.set) + 1'b1 || m_q.set == $past(m_q.set) - 1'b1)); // R7
    AST_NO_SILENT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(m_q.set) |-> m_q.chg); // R6
    AST_EDIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.chg |-> $past(m_q.scr) == SCR_EDIT); // R10
    AST_HOME_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        grant[K_HOME] |=> m_q.scr == SCR_HOME); // R9
    AST_CAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.scr == SCR_CAL && !grant[K_HOME]) |=> m_q.scr == SCR_CAL); // R10
    AST_SCREEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.scr != 2'd3); // R5

endmodule

// File: rtl/keypad_menu.sv
module keypad_menu
    import keymenu_pkg::*;
#(
    parameter int DLY_CYC  = 500000,
    parameter int SET_W    = 8,
    parameter int SET_MIN  = 0,
    parameter int SET_MAX  = 200,
    parameter int SET_INIT = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       key_n,
    output logic [1:0]       screen,
    output logic [SET_W-1:0] setpoint,
    output logic             setpoint_chg
);
    logic [NUM_KEYS-1:0] press_vec;
    logic [NUM_KEYS-1:0] grant_vec;
    screen_e             scr;

    generate
        for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
            key_confirm #(
                .DLY_CYC    (DLY_CYC),
                .SYNC_STAGES(2)
            ) u_kc (
                .clk    (clk),
                .rst_n  (rst_n),
                .key_n  (key_n[k]),
                .press_o(press_vec[k])
            );
        end
    endgenerate

    key_priority u_prio (
        .press(press_vec),
        .grant(grant_vec)
    );

    menu_fsm #(
        .SET_W   (SET_W),
        .SET_MIN (SET_MIN),
        .SET_MAX (SET_MAX),
        .SET_INIT(SET_INIT)
    ) u_menu (
        .clk     (clk),
        .rst_n   (rst_n),
        .grant   (grant_vec),
        .screen_o(scr),
        .set_o   (setpoint),
        .chg_o   (setpoint_chg)
    );

    assign screen = scr;

    AST_HOME_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        press_vec[K_HOME] |=> screen == 2'd0); // R11
    AST_PRESS_GATES_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        setpoint_chg |-> $past(press_vec[K_INC] || press_vec[K_DEC])); // R4

endmodule

// File: tb/keypad_menu_tb.sv
module keypad_menu_tb;
    localparam int D    = 20;
    localparam int SW   = 8;
    localparam int SMIN = 2;
    localparam int SMAX = 5;
    localparam int SINI = 3;
    localparam int HOLD = 40;
    localparam int GAP  = D + 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    key_n = 4'hF;
    logic [1:0]    screen;
    logic [SW-1:0] setpoint;
    logic          setpoint_chg;

    int tests = 0;
    int fails = 0;
    int strobes = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    keypad_menu #(
        .DLY_CYC(D), .SET_W(SW), .SET_MIN(SMIN), .SET_MAX(SMAX), .SET_INIT(SINI)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .key_n(key_n),
        .screen(screen), .setpoint(setpoint), .setpoint_chg(setpoint_chg)
    );

    // behavioural reference model
    int m_phase[4];
    int m_cnt[4];
    bit m_s1[4];
    bit m_s2[4];
    bit m_pend[4];
    int m_scr;
    int m_set;
    bit m_chg;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) begin
                m_phase[k] = 0; m_cnt[k] = 0; m_s1[k] = 1; m_s2[k] = 1; m_pend[k] = 0;
            end
            m_scr = 0; m_set = SINI; m_chg = 0;
        end else begin
            bit np[4];
            m_chg = 0;
            if (m_pend[3]) m_scr = 0;
            else if (m_pend[2]) begin
                if (m_scr == 1 && m_set > SMIN) begin m_set--; m_chg = 1; end
            end else if (m_pend[1]) begin
                if (m_scr == 1 && m_set < SMAX) begin m_set++; m_chg = 1; end
            end else if (m_pend[0]) begin
                if (m_scr < 2) m_scr++;
            end
            for (int k = 0; k < 4; k++) begin
                bit lv;
                lv = m_s2[k];
                m_s2[k] = m_s1[k];
                m_s1[k] = key_n[k];
                np[k] = 0;
                case (m_phase[k])
                    0: if (!lv) begin m_phase[k] = 1; m_cnt[k] = 0; end
                    1: if (m_cnt[k] == D - 1) begin
                           if (!lv) begin m_phase[k] = 2; np[k] = 1; end
                           else m_phase[k] = 0;
                       end else m_cnt[k]++;
                    2: if (lv) begin m_phase[k] = 3; m_cnt[k] = 0; end
                    default: if (m_cnt[k] == D - 1) m_phase[k] = lv ? 0 : 2;
                             else m_cnt[k]++;
                endcase
            end
            for (int k = 0; k < 4; k++) m_pend[k] = np[k];
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            tests++;
            if (screen != 2'(m_scr) || setpoint != SW'(m_set) || setpoint_chg != m_chg) begin
                fails++;
                $display("FAIL %s model: act scr=%0d set=%0d chg=%0d exp scr=%0d set=%0d chg=%0d",
                         cur_req, screen, setpoint, setpoint_chg, m_scr, m_set, m_chg);
            end
            if (setpoint_chg) strobes++;
        end
    end

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic tap(int k, int hold);
        @(negedge clk) key_n[k] = 1'b0;
        repeat (hold) @(negedge clk);
        key_n[k] = 1'b1;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic tap2(int a, int b);
        @(negedge clk) begin key_n[a] = 1'b0; key_n[b] = 1'b0; end
        repeat (HOLD) @(negedge clk);
        key_n[a] = 1'b1; key_n[b] = 1'b1;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic summary();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: act=timeout exp=finish");
        summary();
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        check("R1 screen", screen, 0);
        check("R1 setpoint", setpoint, SINI);
        check("R1 strobe", setpoint_chg, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        cur_req = "R2";
        tap(0, 5);
        check("R2 glitch ignored", screen, 0);

        cur_req = "R10";
        s0 = strobes;
        tap(1, HOLD);
        check("R10 inc on home", setpoint, SINI);
        check("R10 no strobe home", strobes - s0, 0);

        cur_req = "R5";
        tap(0, HOLD);
        check("R5 home to edit", screen, 1);

        cur_req = "R4";
        s0 = strobes;
        tap(1, 300);
        check("R4 long hold one step", setpoint, 4);
        check("R6 one strobe", strobes - s0, 1);

        cur_req = "R6";
        tap(1, HOLD);
        check("R6 inc to max", setpoint, 5);
        s0 = strobes;
        tap(1, HOLD);
        check("R6 max holds", setpoint, 5);
        check("R6 no strobe at max", strobes - s0, 0);

        cur_req = "R7";
        tap(2, HOLD); tap(2, HOLD); tap(2, HOLD);
        check("R7 dec to min", setpoint, 2);
        s0 = strobes;
        tap(2, HOLD);
        check("R7 min holds", setpoint, 2);
        check("R7 no strobe at min", strobes - s0, 0);

        cur_req = "R3";
        @(negedge clk) key_n[1] = 1'b0;
        repeat (HOLD) @(negedge clk);
        key_n[1] = 1'b1;
        repeat (5) @(negedge clk);
        key_n[1] = 1'b0;
        repeat (HOLD) @(negedge clk);
        key_n[1] = 1'b1;
        repeat (GAP) @(negedge clk);
        check("R3 blip no second step", setpoint, 3);

        cur_req = "R11";
        tap2(0, 1);
        check("R11 inc beats enter set", setpoint, 4);
        check("R11 inc beats enter scr", screen, 1);

        cur_req = "R8";
        tap(0, HOLD);
        check("R8 edit to cal", screen, 2);

        cur_req = "R10";
        tap(0, HOLD);
        check("R10 enter on cal", screen, 2);
        tap(2, HOLD);
        check("R10 dec on cal", setpoint, 4);

        cur_req = "R9";
        tap(3, HOLD);
        check("R9 cal to home", screen, 0);
        check("R9 setpoint kept", setpoint, 4);
        tap(0, HOLD);
        tap(3, HOLD);
        check("R9 edit to home", screen, 0);

        cur_req = "R11";
        tap2(3, 0);
        check("R11 home beats enter", screen, 0);

        summary();
    end
endmodule